// File: doc/BRIEF.md
# Serial Flash Command Shifter

This block runs one complete serial flash transaction as an SPI master in mode 0. The clock idles low, data is shifted most significant bit first, MOSI changes on the falling SCLK edge and MISO is sampled on the rising edge. A request carries these fields:

- an 8-bit opcode,
- an address length of zero to four bytes,
- a 32-bit address,
- a data length,
- a direction bit.

The engine pulls chip select low and shifts the opcode. It then shifts the address bytes, most significant byte first, followed by the data bytes. Chip select is released only after the last bit, and a one-cycle completion pulse follows the release. A length of zero drops that phase. A write-enable command, for example, is the opcode byte alone.

Write data enters on a valid/ready byte stream and read data leaves on another. Back-pressure on either stream holds the serial clock low between bytes and keeps chip select low, so no byte is lost.

Stream handshake rules:

- A byte moves on a rising system clock edge where both valid and ready are high.
- `wr_ready` does not depend on `wr_valid`.
- Once `rd_valid` is raised, it and `rd_data` hold until `rd_ready` is seen.

The SCLK rate is the system clock divided by an even divisor. The divisor is captured when a request is accepted. A package supplies opcode constants for the usual flash commands.

Top module: `sfc_shifter`

## Requirements
- R1: After reset, `spi_cs_n` is 1, `spi_sclk` is 0, `req_ready` is 1, `done` is 0 and `rd_valid` is 0.
- R2: `spi_cs_n` falls when a request is accepted and stays 0 until the final bit's falling SCLK edge has passed. `done` is high for exactly one cycle, and that cycle comes one cycle after `spi_cs_n` returned to 1.
- R3: The opcode is the first byte on MOSI. The address bytes follow it. With N address bytes, byte i is `req_addr[8*(N-1-i)+7 : 8*(N-1-i)]`, and counts above 4 act as 4.
- R4: A zero address count or a zero data count removes that phase. A transaction produces exactly 8*(1+N+D) rising SCLK edges, where N is the address count and D is the data count.
- R5: With `req_is_read`=1 the data phase drives 0x00 on MOSI. Each byte captured from MISO, MSB first on rising SCLK edges, is delivered in order on `rd_data`.
- R6: With `req_is_read`=0 each data byte is taken from the write stream and shifted MSB first. While the engine waits for `wr_valid`, SCLK stays 0 and `spi_cs_n` stays 0.
- R7: A new read byte is not shifted while `rd_valid` is pending. `rd_valid` and `rd_data` stay stable until `rd_ready`.
- R8: Each SCLK high phase lasts `sclk_div`/2 system cycles, rounded down. A divisor below 2 acts as 2. MOSI is stable while SCLK is high.
- R9: `req_ready` is 1 only while the engine is idle. A request presented while busy is ignored and does not start another transaction.
- R10: The package opcodes are: read 0x03, page program 0x02, sector erase 0x20, chip erase 0xC7, parameter-table read 0x5A, write enable 0x06, write disable 0x04, read status 0x05 and read ID 0x9F. The opcode shifted is exactly the requested one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk_div | input | DIV_W | SCLK divisor, captured on request accept |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Engine idle, request may be accepted |
| req_opcode | input | 8 | Command byte |
| req_addr_cnt | input | 3 | Address byte count, 0..4 |
| req_addr | input | 32 | Address value |
| req_data_cnt | input | DCNT_W | Data byte count |
| req_is_read | input | 1 | 1 = read data phase, 0 = write |
| wr_valid | input | 1 | Write byte present |
| wr_ready | output | 1 | Engine takes write byte |
| wr_data | input | 8 | Write byte |
| rd_valid | output | 1 | Read byte present |
| rd_ready | input | 1 | Consumer takes read byte |
| rd_data | output | 8 | Read byte |
| done | output | 1 | One-cycle completion pulse |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_sclk | output | 1 | Serial clock, idle low |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |

## Verification
The in-line assertions watch several relations on every cycle:

- SCLK only toggles while chip select is low.
- MOSI holds while SCLK is high.
- A write byte is taken only with SCLK low.
- The read output holds under back-pressure.
- `done` follows a chip-select release.
- `req_ready` implies a deselected device.
- The half-period counter never passes its limit.

Byte order, address slicing, phase skipping, the exact number of SCLK edges, divisor clamping and the refusal of busy requests can only be shown by the bench's scenarios. The bench checks these against a slave model that records MOSI and returns a known MISO pattern.

// File: rtl/sfc_pkg.sv
package sfc_pkg;

  localparam logic [7:0] OP_READ         = 8'h03;
  localparam logic [7:0] OP_PROGRAM      = 8'h02;
  localparam logic [7:0] OP_ERASE_SECTOR = 8'h20;
  localparam logic [7:0] OP_ERASE_ALL    = 8'hC7;
  localparam logic [7:0] OP_READ_PARAM   = 8'h5A;
  localparam logic [7:0] OP_WR_ENABLE    = 8'h06;
  localparam logic [7:0] OP_WR_DISABLE   = 8'h04;
  localparam logic [7:0] OP_READ_STATUS  = 8'h05;
  localparam logic [7:0] OP_READ_IDENT   = 8'h9F;

  localparam int unsigned MAX_ADDR_BYTES = 4;

  typedef enum logic [1:0] {
    BS_IDLE,
    BS_LOW,
    BS_HIGH
  } bit_state_e;

  typedef enum logic [1:0] {
    SQ_IDLE,
    SQ_SHIFT,
    SQ_NEXT,
    SQ_RELEASE
  } seq_state_e;

  typedef enum logic [1:0] {
    PH_OPCODE,
    PH_ADDR,
    PH_DATA
  } phase_e;

endpackage

// File: rtl/sfc_half_timer.sv
module sfc_half_timer #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] half,
  output logic             tick
);

  logic [DIV_W-1:0] cnt;

  assign tick = run && (cnt == (half - DIV_W'(1)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (!run || tick) begin
      cnt <= '0;
    end else begin
      cnt <= cnt + DIV_W'(1);
    end
  end

  AST_TICK_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cnt < half)); // R8

endmodule

// File: rtl/sfc_bit_engine.sv
module sfc_bit_engine
  import sfc_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [7:0]       tx_byte,
  input  logic [DIV_W-1:0] half,
  input  logic             miso,
  output logic             sclk,
  output logic             mosi,
  output logic             byte_done,
  output logic [7:0]       rx_byte
);

  bit_state_e st;
  logic [7:0] tx_sr;
  logic [7:0] rx_sr;
  logic [2:0] bit_idx;
  logic       sclk_q;
  logic       done_q;
  logic       tick;

  sfc_half_timer #(.DIV_W(DIV_W)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (st != BS_IDLE),
    .half  (half),
    .tick  (tick)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= BS_IDLE;
      tx_sr   <= '0;
      rx_sr   <= '0;
      bit_idx <= '0;
      sclk_q  <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (st)
        BS_IDLE: begin
          if (start) begin
            tx_sr   <= tx_byte;
            bit_idx <= '0;
            st      <= BS_LOW;
          end
        end
        BS_LOW: begin
          if (tick) begin
            sclk_q <= 1'b1;
            rx_sr  <= {rx_sr[6:0], miso};
            st     <= BS_HIGH;
          end
        end
        BS_HIGH: begin
          if (tick) begin
            sclk_q <= 1'b0;
            if (bit_idx == 3'd7) begin
              st     <= BS_IDLE;
              done_q <= 1'b1;
            end else begin
              bit_idx <= bit_idx + 3'd1;
              tx_sr   <= {tx_sr[6:0], 1'b0};
              st      <= BS_LOW;
            end
          end
        end
        default: st <= BS_IDLE;
      endcase
    end
  end

  assign sclk      = sclk_q;
  assign mosi      = tx_sr[7];
  assign byte_done = done_q;
  assign rx_byte   = rx_sr;

  AST_MOSI_HOLD_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk_q && $past(sclk_q)) |-> $stable(tx_sr[7])); // R8
  AST_START_WHEN_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> (st == BS_IDLE) && !sclk_q); // R2

endmodule

// File: rtl/sfc_sequencer.sv
module sfc_sequencer
  import sfc_pkg::*;
#(
  parameter int DCNT_W = 16,
  parameter int DIV_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DIV_W-1:0]  sclk_div,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [7:0]        req_opcode,
  input  logic [2:0]        req_addr_cnt,
  input  logic [31:0]       req_addr,
  input  logic [DCNT_W-1:0] req_data_cnt,
  input  logic              req_is_read,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [7:0]        wr_data,
  output logic              rd_valid,
  input  logic              rd_ready,
  output logic [7:0]        rd_data,
  output logic              done,
  output logic              cs_n,
  output logic [DIV_W-1:0]  half,
  output logic              eng_start,
  output logic [7:0]        eng_tx,
  input  logic              eng_done,
  input  logic [7:0]        eng_rx
);

  localparam logic [2:0] ACNT_MAX = 3'(MAX_ADDR_BYTES);

  seq_state_e        st;
  phase_e            phase;
  logic [31:0]       addr_q;
  logic [2:0]        addr_left;
  logic [DCNT_W-1:0] data_left;
  logic              is_read_q;
  logic [DIV_W-1:0]  half_q;
  logic              cs_n_q;
  logic              done_q;
  logic              rd_valid_q;
  logic [7:0]        rd_data_q;
  logic              accept;
  logic [7:0]        addr_byte;
  logic [2:0]        acnt_eff;
  logic [DIV_W-1:0]  half_req;
  logic              data_phase_open;

  assign req_ready       = (st == SQ_IDLE);
  assign accept          = req_valid && req_ready;
  assign acnt_eff        = (req_addr_cnt > ACNT_MAX) ? ACNT_MAX : req_addr_cnt;
  assign half_req        = (sclk_div < DIV_W'(2)) ? DIV_W'(1) : (sclk_div >> 1);
  assign data_phase_open = (st == SQ_NEXT) && (addr_left == 3'd0) && (data_left != '0);
  assign wr_ready        = data_phase_open && !is_read_q;

  always_comb begin
    case (addr_left)
      3'd1:    addr_byte = addr_q[7:0];
      3'd2:    addr_byte = addr_q[15:8];
      3'd3:    addr_byte = addr_q[23:16];
      default: addr_byte = addr_q[31:24];
    endcase
  end

  always_comb begin
    eng_start = 1'b0;
    eng_tx    = 8'h00;
    if (accept) begin
      eng_start = 1'b1;
      eng_tx    = req_opcode;
    end else if (st == SQ_NEXT) begin
      if (addr_left != 3'd0) begin
        eng_start = 1'b1;
        eng_tx    = addr_byte;
      end else if (data_left != '0) begin
        if (is_read_q) begin
          eng_start = !rd_valid_q;
        end else if (wr_valid) begin
          eng_start = 1'b1;
          eng_tx    = wr_data;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= SQ_IDLE;
      phase      <= PH_OPCODE;
      addr_q     <= '0;
      addr_left  <= '0;
      data_left  <= '0;
      is_read_q  <= 1'b0;
      half_q     <= DIV_W'(1);
      cs_n_q     <= 1'b1;
      done_q     <= 1'b0;
      rd_valid_q <= 1'b0;
      rd_data_q  <= '0;
    end else begin
      done_q <= 1'b0;
      if (rd_valid_q && rd_ready) begin
        rd_valid_q <= 1'b0;
      end
      case (st)
        SQ_IDLE: begin
          if (accept) begin
            addr_q    <= req_addr;
            addr_left <= acnt_eff;
            data_left <= req_data_cnt;
            is_read_q <= req_is_read;
            half_q    <= half_req;
            cs_n_q    <= 1'b0;
            phase     <= PH_OPCODE;
            st        <= SQ_SHIFT;
          end
        end
        SQ_SHIFT: begin
          if (eng_done) begin
            if (phase == PH_DATA && is_read_q) begin
              rd_valid_q <= 1'b1;
              rd_data_q  <= eng_rx;
            end
            st <= SQ_NEXT;
          end
        end
        SQ_NEXT: begin
          if (eng_start) begin
            st <= SQ_SHIFT;
            if (addr_left != 3'd0) begin
              addr_left <= addr_left - 3'd1;
              phase     <= PH_ADDR;
            end else begin
              data_left <= data_left - DCNT_W'(1);
              phase     <= PH_DATA;
            end
          end else if (addr_left == 3'd0 && data_left == '0) begin
            cs_n_q <= 1'b1;
            st     <= SQ_RELEASE;
          end
        end
        SQ_RELEASE: begin
          done_q <= 1'b1;
          st     <= SQ_IDLE;
        end
        default: st <= SQ_IDLE;
      endcase
    end
  end

  assign rd_valid = rd_valid_q;
  assign rd_data  = rd_data_q;
  assign done     = done_q;
  assign cs_n     = cs_n_q;
  assign half     = half_q;

  AST_DONE_AFTER_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> cs_n_q && $past(cs_n_q)); // R2
  AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid_q && !rd_ready) |=> rd_valid_q && $stable(rd_data_q)); // R7
  AST_BYTE_INSIDE_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
    eng_done |-> !cs_n_q); // R2

endmodule

// File: rtl/sfc_shifter.sv
module sfc_shifter
  import sfc_pkg::*;
#(
  parameter int DCNT_W = 16,
  parameter int DIV_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DIV_W-1:0]  sclk_div,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [7:0]        req_opcode,
  input  logic [2:0]        req_addr_cnt,
  input  logic [31:0]       req_addr,
  input  logic [DCNT_W-1:0] req_data_cnt,
  input  logic              req_is_read,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [7:0]        wr_data,
  output logic              rd_valid,
  input  logic              rd_ready,
  output logic [7:0]        rd_data,
  output logic              done,
  output logic              spi_cs_n,
  output logic              spi_sclk,
  output logic              spi_mosi,
  input  logic              spi_miso
);

  logic [DIV_W-1:0] half;
  logic             eng_start;
  logic [7:0]       eng_tx;
  logic             eng_done;
  logic [7:0]       eng_rx;

  sfc_sequencer #(.DCNT_W(DCNT_W), .DIV_W(DIV_W)) u_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .sclk_div     (sclk_div),
    .req_valid    (req_valid),
    .req_ready    (req_ready),
    .req_opcode   (req_opcode),
    .req_addr_cnt (req_addr_cnt),
    .req_addr     (req_addr),
    .req_data_cnt (req_data_cnt),
    .req_is_read  (req_is_read),
    .wr_valid     (wr_valid),
    .wr_ready     (wr_ready),
    .wr_data      (wr_data),
    .rd_valid     (rd_valid),
    .rd_ready     (rd_ready),
    .rd_data      (rd_data),
    .done         (done),
    .cs_n         (spi_cs_n),
    .half         (half),
    .eng_start    (eng_start),
    .eng_tx       (eng_tx),
    .eng_done     (eng_done),
    .eng_rx       (eng_rx)
  );

  sfc_bit_engine #(.DIV_W(DIV_W)) u_eng (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (eng_start),
    .tx_byte   (eng_tx),
    .half      (half),
    .miso      (spi_miso),
    .sclk      (spi_sclk),
    .mosi      (spi_mosi),
    .byte_done (eng_done),
    .rx_byte   (eng_rx)
  );

  AST_SCLK_ONLY_SELECTED: assert property (@(posedge clk) disable iff (!rst_n)
    spi_sclk |-> !spi_cs_n); // R2
  AST_READY_MEANS_DESELECTED: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> spi_cs_n); // R9
  AST_WR_TAKE_SCLK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_ready) |-> (!spi_sclk && !spi_cs_n)); // R6

endmodule

// File: tb/sfc_shifter_tb_top.sv
`timescale 1ns/1ps
module sfc_shifter_tb_top;
  import sfc_pkg::*;

  localparam int DCNT_W = 16;
  localparam int DIV_W  = 8;

  logic              clk;
  logic              rst_n;
  logic [DIV_W-1:0]  sclk_div;
  logic              req_valid;
  logic              req_ready;
  logic [7:0]        req_opcode;
  logic [2:0]        req_addr_cnt;
  logic [31:0]       req_addr;
  logic [DCNT_W-1:0] req_data_cnt;
  logic              req_is_read;
  logic              wr_valid;
  logic              wr_ready;
  logic [7:0]        wr_data;
  logic              rd_valid;
  logic              rd_ready;
  logic [7:0]        rd_data;
  logic              done;
  logic              spi_cs_n;
  logic              spi_sclk;
  logic              spi_mosi;
  logic              spi_miso;

  sfc_shifter #(.DCNT_W(DCNT_W), .DIV_W(DIV_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .sclk_div(sclk_div),
    .req_valid(req_valid), .req_ready(req_ready), .req_opcode(req_opcode),
    .req_addr_cnt(req_addr_cnt), .req_addr(req_addr), .req_data_cnt(req_data_cnt),
    .req_is_read(req_is_read), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_data(wr_data), .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data),
    .done(done), .spi_cs_n(spi_cs_n), .spi_sclk(spi_sclk), .spi_mosi(spi_mosi),
    .spi_miso(spi_miso)
  );

  int n_cmp = 0;
  int n_bad = 0;
  int cyc = 0;
  int exp_half = 1;
  int total_rises = 0;
  int cs_falls = 0;
  int done_count = 0;
  int wr_gap = 0;
  bit rd_stall = 0;
  logic [7:0] exp_mosi[$];
  logic [7:0] exp_rd[$];
  logic [7:0] wr_q[$];

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h (t=%0t)", req, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] resp(input int k);
    return 8'((k * 59 + 92) % 256);
  endfunction

  initial begin
    clk = 1'b0;
    forever #2.5 clk = ~clk;
  end

  always @(posedge clk) cyc++;

  always @(posedge clk) begin
    if (cyc > 150000) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog expired actual=%0d expected=<150000", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  // Slave model: records MOSI and returns resp(k) for byte k of each selection.
  initial begin
    logic prev_cs;
    logic prev_sclk;
    logic [7:0] mosi_sh;
    logic [7:0] b;
    int rise_cnt;
    prev_cs = 1'b1;
    prev_sclk = 1'b0;
    mosi_sh = '0;
    rise_cnt = 0;
    spi_miso = 1'b0;
    forever begin
      @(spi_cs_n or spi_sclk);
      if (prev_cs && !spi_cs_n) begin
        cs_falls++;
        rise_cnt = 0;
        b = resp(0);
        spi_miso = b[7];
      end else if (!prev_sclk && spi_sclk && !spi_cs_n) begin
        mosi_sh = {mosi_sh[6:0], spi_mosi};
        rise_cnt++;
        total_rises++;
        if (rise_cnt % 8 == 0) begin
          if (exp_mosi.size() == 0) begin
            chk(1'b0, "R3 unexpected MOSI byte", 64'(mosi_sh), 64'hFFFF);
          end else begin
            b = exp_mosi.pop_front();
            chk(mosi_sh == b, "R3/R5/R6 MOSI byte", 64'(mosi_sh), 64'(b));
          end
        end
      end else if (prev_sclk && !spi_sclk && !spi_cs_n) begin
        b = resp(rise_cnt / 8);
        spi_miso = b[7 - (rise_cnt % 8)];
      end
      prev_cs = spi_cs_n;
      prev_sclk = spi_sclk;
    end
  end

  // Read-side back-pressure driver
  always @(posedge clk) begin
    #1;
    rd_ready = rd_stall ? (cyc % 5 == 0) : 1'b1;
  end

  // Monitor: read stream scoreboard, done timing, SCLK high time, write stall
  initial begin
    logic h1;
    logic h2;
    int hi_len;
    logic [7:0] e;
    h1 = 1'b1;
    h2 = 1'b1;
    hi_len = 0;
    forever begin
      @(negedge clk);
      if (rst_n) begin
        if (rd_valid && rd_ready) begin
          if (exp_rd.size() == 0) begin
            chk(1'b0, "R5 unexpected read byte", 64'(rd_data), 64'hFFFF);
          end else begin
            e = exp_rd.pop_front();
            chk(rd_data == e, "R5/R7 read byte", 64'(rd_data), 64'(e));
          end
        end
        if (done) begin
          done_count++;
          chk(spi_cs_n && h1 && !h2, "R2 done one cycle after CS release",
              64'({spi_cs_n, h1, h2}), 64'b110);
        end
        if (spi_sclk) begin
          hi_len++;
        end else if (hi_len > 0) begin
          chk(hi_len == exp_half, "R8 SCLK high time", 64'(hi_len), 64'(exp_half));
          hi_len = 0;
        end
        if (wr_ready && !wr_valid) begin
          chk(!spi_sclk && !spi_cs_n, "R6 stall keeps SCLK low and CS low",
              64'({spi_sclk, spi_cs_n}), 64'b00);
        end
        h2 = h1;
        h1 = spi_cs_n;
      end
    end
  end

  // Write-stream driver with optional bubbles
  initial begin
    int gap_cnt;
    gap_cnt = 0;
    wr_valid = 1'b0;
    wr_data = 8'h00;
    forever begin
      @(negedge clk);
      if (wr_valid && wr_ready) begin
        @(posedge clk);
        #1;
        wr_valid = 1'b0;
        void'(wr_q.pop_front());
        gap_cnt = wr_gap;
      end else if (!wr_valid && wr_q.size() > 0) begin
        if (gap_cnt > 0) begin
          gap_cnt--;
        end else begin
          wr_valid = 1'b1;
          wr_data = wr_q[0];
        end
      end
    end
  end

  task automatic run_txn(input logic [7:0] op, input int acnt, input logic [31:0] addr,
                         input int dcnt, input bit rd, input int div, input bit poke);
    int rises0;
    int falls0;
    int dones0;
    int drain;
    logic [7:0] wb;
    exp_half = (div < 2) ? 1 : div / 2;
    exp_mosi.push_back(op);
    for (int i = 0; i < acnt; i++) begin
      exp_mosi.push_back(8'(addr >> (8 * (acnt - 1 - i))));
    end
    for (int i = 0; i < dcnt; i++) begin
      if (rd) begin
        exp_mosi.push_back(8'h00);
        exp_rd.push_back(resp(1 + acnt + i));
      end else begin
        wb = 8'((op ^ 8'(i * 17 + 3)) + 8'(i));
        wr_q.push_back(wb);
        exp_mosi.push_back(wb);
      end
    end
    rises0 = total_rises;
    falls0 = cs_falls;
    dones0 = done_count;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    sclk_div = DIV_W'(div);
    req_opcode = op;
    req_addr_cnt = 3'(acnt);
    req_addr = addr;
    req_data_cnt = DCNT_W'(dcnt);
    req_is_read = rd;
    req_valid = 1'b1;
    @(negedge clk);
    if (poke) begin
      req_opcode = OP_ERASE_ALL;
      req_addr_cnt = 3'd0;
      req_data_cnt = '0;
      chk(!req_ready, "R9 req_ready low while busy", 64'(req_ready), 64'd0);
    end else begin
      req_valid = 1'b0;
    end
    while (done_count == dones0) begin
      if (poke && spi_cs_n) req_valid = 1'b0;
      @(negedge clk);
    end
    req_valid = 1'b0;
    drain = 0;
    while (exp_rd.size() > 0 && drain < 40) begin
      @(negedge clk);
      drain++;
    end
    chk(total_rises - rises0 == 8 * (1 + acnt + dcnt), "R4 SCLK rising edge count",
        64'(total_rises - rises0), 64'(8 * (1 + acnt + dcnt)));
    chk(exp_mosi.size() == 0, "R3 all MOSI bytes seen", 64'(exp_mosi.size()), 64'd0);
    chk(exp_rd.size() == 0, "R5 all read bytes delivered", 64'(exp_rd.size()), 64'd0);
    chk(cs_falls - falls0 == 1, "R9 one selection per request", 64'(cs_falls - falls0), 64'd1);
  endtask

  initial begin
    rst_n = 1'b0;
    sclk_div = DIV_W'(2);
    req_valid = 1'b0;
    req_opcode = 8'h00;
    req_addr_cnt = 3'd0;
    req_addr = '0;
    req_data_cnt = '0;
    req_is_read = 1'b0;
    rd_ready = 1'b1;
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk(spi_cs_n == 1'b1, "R1 CS idle high", 64'(spi_cs_n), 64'd1);
    chk(spi_sclk == 1'b0, "R1 SCLK idle low", 64'(spi_sclk), 64'd0);
    chk(req_ready == 1'b1, "R1 ready after reset", 64'(req_ready), 64'd1);
    chk(done == 1'b0 && rd_valid == 1'b0, "R1 done and rd_valid low",
        64'({done, rd_valid}), 64'd0);

    // R4 R10: opcode-only write enable
    run_txn(OP_WR_ENABLE, 0, 32'h0, 0, 1'b0, 2, 1'b0);
    // R5: status read, one byte, divisor 4
    run_txn(OP_READ_STATUS, 0, 32'h0, 1, 1'b1, 4, 1'b0);
    // R3 R5 R7: 3-byte address read with consumer stalls
    rd_stall = 1'b1;
    run_txn(OP_READ, 3, 32'h00123456, 4, 1'b1, 2, 1'b0);
    rd_stall = 1'b0;
    // R6: page program with producer bubbles, divisor 6
    wr_gap = 3;
    run_txn(OP_PROGRAM, 3, 32'h000A0B0C, 3, 1'b0, 6, 1'b0);
    wr_gap = 0;
    // R3 R8: 4-byte address, divisor 0 clamps to 2
    run_txn(OP_READ_PARAM, 4, 32'hDEADBEEF, 2, 1'b1, 0, 1'b0);
    // R4 R8 R9: address-only erase, odd divisor, request held while busy
    run_txn(OP_ERASE_SECTOR, 3, 32'h0000F000, 0, 1'b0, 7, 1'b1);
    // R10: identification read
    run_txn(OP_READ_IDENT, 0, 32'h0, 3, 1'b1, 2, 1'b0);
    run_txn(OP_WR_DISABLE, 0, 32'h0, 0, 1'b0, 2, 1'b0);

    repeat (20) @(negedge clk);
    chk(spi_cs_n == 1'b1, "R9 no extra transaction after busy request", 64'(spi_cs_n), 64'd1);
    chk(cs_falls == 8, "R9 selection count", 64'(cs_falls), 64'd8);
    chk(done_count == 8, "R2 done count", 64'(done_count), 64'd8);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule